// File: doc/BRIEF.md
# IrDA SIR Pulse Decoder

This block sits between an infrared transceiver's receive pin and an ordinary UART receiver. Its clock runs at sixteen times the baud rate. An IrDA SIR link marks each zero bit with a short light pulse three sixteenths of a bit period wide and leaves one bits dark. The decoder finds those pulses and rebuilds a level-coded serial line, so the UART receiver behind it sees normal start, data and stop bits.

The pin first passes a polarity stage. By default, with `keepPolarity` low, the pin is inverted, because common transceivers drive their output low while light is present. The result then goes through a two-flop synchronizer. A pulse is accepted only if it is seen on a minimum number of consecutive clock samples, which is two by default. Each accepted pulse drives the rebuilt line low for one bit period of sixteen clocks and raises a one-cycle strobe. A new pulse that arrives inside that period starts the period again. The link is half duplex. While the device transmits, and also while receive is switched off, the rebuilt line is held at the idle level and no pulse is accepted.

Top module: `irsir_decoder`

## Requirements
- R1: During and right after reset, `rxOut` is 1 and `pulseDet` is 0.
- R2: With `keepPolarity`=0 a low pin level is a pulse and a high level is idle. With `keepPolarity`=1 a high pin level is a pulse and a low level is idle.
- R3: For a pulse two or more clocks wide, `pulseDet` is high on the third rising edge after the edge that first samples the pin active. It stays high for exactly one cycle.
- R4: A pulse seen on only one clock sample is a glitch. It raises no `pulseDet` and leaves `rxOut` at 1.
- R5: An accepted pulse drives `rxOut` low for exactly 16 cycles, starting in the same cycle that `pulseDet` goes high.
- R6: A pulse accepted while `rxOut` is already low restarts the 16-cycle low period. Pulses arriving every 16 cycles therefore give one unbroken low stretch.
- R7: A pin held active for many cycles gives only one `pulseDet` and one 16-cycle low period.
- R8: While `txActive` is 1, `rxOut` is 1 and no pulse is accepted.
- R9: While `rxDisable` is 1, `rxOut` is 1 and no pulse is accepted.
- R10: When blanking (`txActive` or `rxDisable`) starts in the middle of a low period, `rxOut` rises in the same cycle. The rest of that period is cancelled and does not return when blanking ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 16x the baud rate |
| rstN | input | 1 | Asynchronous reset, active low |
| irPin | input | 1 | Raw transceiver receive pin |
| keepPolarity | input | 1 | 0 inverts the pin (default use), 1 passes it unchanged |
| rxDisable | input | 1 | 1 switches the receive path off |
| txActive | input | 1 | 1 while the device is transmitting |
| rxOut | output | 1 | Rebuilt level-coded RX line, idle high |
| pulseDet | output | 1 | One-cycle strobe for each accepted pulse |

## Verification
If the bit-window counter is corrupted, the length of each low stretch on `rxOut` changes by the same number of cycles. This is visible within 16 cycles of the pulse. If the run-length counter or the synchronizer is wrong, `pulseDet` moves away from the third edge after sampling, or a one-sample glitch or a long active level produces the wrong number of strobes. This is visible within four cycles. If the blanking path is wrong, `rxOut` stays low in the same cycle that `txActive` or `rxDisable` rises.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic holdIdle;  // force the rebuilt line high right now
    logic clearAll;  // wipe run length and bit window at the next edge
    logic startBit;  // load a fresh zero-bit window at the next edge
  } irsirStrobe_t;
endpackage

// File: rtl/irsir_datapath.sv
module irsir_datapath
  import irsir_pkg::*;
#(
  parameter int BitTicks      = 16,
  parameter int MinPulseTicks = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         irPin,
  input  logic         keepPolarity,
  input  irsirStrobe_t st,
  output logic         pulseLvl,
  output logic [$clog2(MinPulseTicks+1)-1:0] runLen,
  output logic         rxOut,
  output logic         pulseDet
);
  localparam int WinW = $clog2(BitTicks + 1);
  localparam int RunW = $clog2(MinPulseTicks + 1);
  localparam int SyncStages = 2;

  logic [SyncStages-1:0] syncQ;
  logic [WinW-1:0]       window;
  logic                  activeIn;

  // Polarity stage ahead of the synchronizer: active level becomes 1
  assign activeIn = keepPolarity ? irPin : ~irPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SyncStages-2:0], activeIn};
  end
  assign pulseLvl = syncQ[SyncStages-1];

  // Consecutive active samples, saturating at the qualification width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         runLen <= '0;
    else if (st.clearAll || !pulseLvl) runLen <= '0;
    else if (runLen != RunW'(MinPulseTicks)) runLen <= runLen + 1'b1;
  end

  // Zero-bit window: counts down from BitTicks, line low while nonzero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             window <= '0;
    else if (st.clearAll)  window <= '0;
    else if (st.startBit)  window <= WinW'(BitTicks);
    else if (window != '0) window <= window - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseDet <= 1'b0;
    else       pulseDet <= st.startBit;
  end

  assign rxOut = st.holdIdle || (window == '0);
endmodule

// File: rtl/irsir_control.sv
module irsir_control
  import irsir_pkg::*;
#(
  parameter int MinPulseTicks = 2
) (
  input  logic rxDisable,
  input  logic txActive,
  input  logic pulseLvl,
  input  logic [$clog2(MinPulseTicks+1)-1:0] runLen,
  output irsirStrobe_t st
);
  localparam int RunW = $clog2(MinPulseTicks + 1);

  logic blank;
  assign blank = rxDisable || txActive;

  always_comb begin
    st          = '0;
    st.holdIdle = blank;
    st.clearAll = blank;
    // Accept on the sample that completes the minimum run
    st.startBit = !blank && pulseLvl && (runLen == RunW'(MinPulseTicks - 1));
  end
endmodule

// File: rtl/irsir_decoder.sv
module irsir_decoder
  import irsir_pkg::*;
#(
  parameter int BitTicks      = 16,
  parameter int MinPulseTicks = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic irPin,
  input  logic keepPolarity,
  input  logic rxDisable,
  input  logic txActive,
  output logic rxOut,
  output logic pulseDet
);
  localparam int RunW = $clog2(MinPulseTicks + 1);

  irsirStrobe_t    st;
  logic            pulseLvl;
  logic [RunW-1:0] runLen;

  irsir_control #(.MinPulseTicks(MinPulseTicks)) ctl (
    .rxDisable(rxDisable), .txActive(txActive),
    .pulseLvl(pulseLvl), .runLen(runLen), .st(st)
  );

  irsir_datapath #(.BitTicks(BitTicks), .MinPulseTicks(MinPulseTicks)) dp (
    .clk(clk), .rstN(rstN), .irPin(irPin), .keepPolarity(keepPolarity),
    .st(st), .pulseLvl(pulseLvl), .runLen(runLen),
    .rxOut(rxOut), .pulseDet(pulseDet)
  );
endmodule

// File: rtl/irsir_decoder_chk.sv
module irsir_decoder_chk (
  input logic clk,
  input logic rstN,
  input logic rxDisable,
  input logic txActive,
  input logic rxOut,
  input logic pulseDet
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |-> (rxOut && !pulseDet));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseDet |=> !pulseDet);

  // R5
  low_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseDet && !rxDisable && !txActive) |-> !rxOut);

  // R5
  fall_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxOut) |-> pulseDet);

  // R8
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> rxOut);

  // R9
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDisable |-> rxOut);

  // R8
  no_strobe_blanked_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseDet |-> $past(!rxDisable && !txActive));
endmodule

bind irsir_decoder irsir_decoder_chk chk (
  .clk(clk), .rstN(rstN), .rxDisable(rxDisable), .txActive(txActive),
  .rxOut(rxOut), .pulseDet(pulseDet)
);

// File: tb/irsir_decoder_test.sv
module irsir_decoder_test;
  localparam int ClkPeriod = 10;
  localparam int NumVec = 10;

  typedef struct packed {
    logic       keep;
    logic       dis;
    logic       tx;
    logic [4:0] width;
    logic [1:0] expDet;
    logic [4:0] expLow;
  } vec_t;

  // keep, dis, tx, width, strobes, low cycles
  localparam vec_t Vecs [NumVec] = '{
    '{1'b0, 1'b0, 1'b0, 5'd3,  2'd1, 5'd16},  // R2 R5 inverted pulse
    '{1'b0, 1'b0, 1'b0, 5'd1,  2'd0, 5'd0 },  // R4 glitch
    '{1'b0, 1'b0, 1'b0, 5'd2,  2'd1, 5'd16},  // R4 minimum width accepted
    '{1'b1, 1'b0, 1'b0, 5'd3,  2'd1, 5'd16},  // R2 direct polarity
    '{1'b1, 1'b0, 1'b0, 5'd1,  2'd0, 5'd0 },  // R4 glitch direct
    '{1'b0, 1'b0, 1'b1, 5'd3,  2'd0, 5'd0 },  // R8
    '{1'b0, 1'b1, 1'b0, 5'd3,  2'd0, 5'd0 },  // R9
    '{1'b1, 1'b1, 1'b0, 5'd3,  2'd0, 5'd0 },  // R9 direct
    '{1'b0, 1'b0, 1'b0, 5'd20, 2'd1, 5'd16},  // R7 long level
    '{1'b1, 1'b0, 1'b1, 5'd5,  2'd0, 5'd0 }   // R8 direct
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irPin = 1'b1;
  logic keepPolarity = 1'b0;
  logic rxDisable = 1'b0;
  logic txActive = 1'b0;
  logic rxOut, pulseDet;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  irsir_decoder uut (
    .clk(clk), .rstN(rstN), .irPin(irPin), .keepPolarity(keepPolarity),
    .rxDisable(rxDisable), .txActive(txActive),
    .rxOut(rxOut), .pulseDet(pulseDet)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pinLevel(input bit active);
    return keepPolarity ? active : ~active;
  endfunction

  // Drives up to three pulses (start -1 = unused), samples before driving
  task automatic pulseRun(input int a, input int b, input int c, input int w,
                          input int n, output int lows, output int dets);
    lows = 0; dets = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rxOut) lows++;
      if (pulseDet) dets++;
      irPin = pinLevel((i >= a && i < a + w) ||
                       (b >= 0 && i >= b && i < b + w) ||
                       (c >= 0 && i >= c && i < c + w));
    end
  endtask

  task automatic settle(input bit k, input bit d, input bit t);
    @(negedge clk);
    keepPolarity = k; rxDisable = d; txActive = t;
    irPin = pinLevel(1'b0);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lows, dets;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(rxOut == 1'b1, "R1 rxOut in reset", rxOut, 1);
    check(pulseDet == 1'b0, "R1 pulseDet in reset", pulseDet, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rxOut == 1'b1, "R1 rxOut after reset", rxOut, 1);

    // Vector table
    for (int v = 0; v < NumVec; v++) begin
      settle(Vecs[v].keep, Vecs[v].dis, Vecs[v].tx);
      pulseRun(0, -1, -1, int'(Vecs[v].width), 50, lows, dets);
      check(dets == int'(Vecs[v].expDet), $sformatf("R2/R4/R7/R8/R9 vec%0d strobes", v),
            dets, int'(Vecs[v].expDet));
      check(lows == int'(Vecs[v].expLow), $sformatf("R5 vec%0d low cycles", v),
            lows, int'(Vecs[v].expLow));
    end

    // R3 and R5 exact timing: pin active from negedge 0, first sampled at edge 1
    settle(1'b0, 1'b0, 1'b0);
    for (int i = 0; i <= 21; i++) begin
      @(negedge clk);
      if (i == 3) check(pulseDet == 1'b0, "R3 strobe not early", pulseDet, 0);
      if (i == 4) check(pulseDet == 1'b1, "R3 strobe on third edge", pulseDet, 1);
      if (i == 5) check(pulseDet == 1'b0, "R3 strobe one cycle", pulseDet, 0);
      if (i == 3) check(rxOut == 1'b1, "R5 line high before strobe", rxOut, 1);
      if (i == 4) check(rxOut == 1'b0, "R5 line low with strobe", rxOut, 0);
      if (i == 19) check(rxOut == 1'b0, "R5 line low at cycle 16", rxOut, 0);
      if (i == 20) check(rxOut == 1'b1, "R5 line back high", rxOut, 1);
      irPin = pinLevel(i < 3);
    end

    // R6 pulses every 16 cycles merge into one low stretch
    settle(1'b0, 1'b0, 1'b0);
    pulseRun(0, 16, 32, 3, 70, lows, dets);
    check(dets == 3, "R6 three strobes", dets, 3);
    check(lows == 48, "R6 unbroken low", lows, 48);

    // R6 pulse inside window restarts it
    settle(1'b1, 1'b0, 1'b0);
    pulseRun(0, 8, -1, 3, 50, lows, dets);
    check(lows == 24, "R6 restart window", lows, 24);

    // R10 blanking mid-window
    settle(1'b0, 1'b0, 1'b0);
    lows = 0;
    for (int i = 0; i <= 30; i++) begin
      @(negedge clk);
      if (i == 8) begin
        check(rxOut == 1'b0, "R10 low before blank", rxOut, 0);
        txActive = 1'b1;
        #1 check(rxOut == 1'b1, "R10 immediate idle", rxOut, 1);
      end
      if (i == 9) txActive = 1'b0;
      if (i >= 10 && !rxOut) lows++;
      irPin = pinLevel(i < 3);
    end
    check(lows == 0, "R10 window cancelled", lows, 0);

    // R9 release of disable gives clean reception again
    settle(1'b0, 1'b1, 1'b0);
    @(negedge clk) rxDisable = 1'b0;
    repeat (4) @(negedge clk);
    pulseRun(0, -1, -1, 3, 30, lows, dets);
    check(dets == 1, "R9 receive after enable", dets, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule